// File: doc/BRIEF.md
# 10BASE-T Receive Nibble Framer

This block sits behind the 10 Mbps receive path once the line code has been removed. It takes a serial stream of decoded bits, each marked by a one-clock valid strobe, plus a one-clock end-of-frame pulse. From that stream it drives the receive side of a media-independent interface: a four-bit data nibble, a data-valid flag and a carrier-sense flag. At 10 Mbps there is no scrambling, so received bits go straight into nibbles, least-significant bit first.

The framer first qualifies a preamble: eight alternating bits that start with 1 and end with 0. Carrier sense rises when that happens. The framer then looks for the delimiter, which is the first repeated 1 that ends the alternation. Two frame-level options are sampled when the preamble qualifies:

- Strip or pass. In strip mode the preamble is withheld, and the delimiter byte is presented as nibble 5 and then nibble D. In pass mode the preamble is forwarded from the moment it qualifies.
- Carrier-sense release. Carrier sense either drops one clock after end-of-frame, or drops together with data-valid.

A frame that ends with a partial byte is closed by the dribble rules. One to three leftover bits produce a padded closing nibble. Five to seven leftover bits lose their incomplete upper nibble.

Top module: `rxnib_mii_framer`

## Requirements
- R1: Body nibbles are built least-significant bit first: the first received bit lands on `rxd[0]`. Each nibble appears on `rxd`, with `rx_dv` high, on the clock after the strobe of its fourth bit, and it is held until the next nibble.
- R2: `crs` rises on the clock after the strobe of the eighth bit of an alternating run that starts with 1 and ends with 0. Before that it stays low, and while it is low `rx_dv` is low too.
- R3: When `pre_pass` is 0 at qualification (strip mode), `rx_dv` stays 0 and `rxd` stays 0 through the rest of the preamble. When the delimiter bit arrives (a 1 following a 1), `rx_dv` rises with `rxd`=5 on the next clock, and `rxd`=D on the clock after that.
- R4: When `pre_pass` is 1 at qualification (pass mode), `rx_dv` and `crs` rise on the same clock, with `rxd`=5. `rxd` stays 5 through the preamble and shows D on the clock after the delimiter bit.
- R5: After qualification and before the delimiter, a 0 following a 0 aborts the frame. `crs` falls on the next clock, `rx_dv` never rises, and a new qualification needs eight fresh alternating bits.
- R6: When the body ends on a nibble boundary that completes a byte, or when the only leftover is a full low nibble, `rx_dv` and `crs` fall and `rxd` returns to 0 on the clock after `eof`.
- R7: With 1 to 3 leftover bits, the clock after `eof` shows one closing nibble with `rx_dv` high. Its received bits sit in the low positions and its unfilled positions are 1. On the following clock `rx_dv` falls.
- R8: With 4 to 7 leftover bits, the low nibble is delivered normally after its fourth bit. The incomplete upper nibble is discarded: no further nibble appears, and `rx_dv` falls on the clock after `eof`.
- R9: If `crs_follow_dv` was 0 at qualification, `crs` falls on the clock after `eof`, even while a closing nibble is still shown. If it was 1, `crs` falls on the same clock as `rx_dv`.
- R10: `rxd` is 0 on every clock where `rx_dv` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_pass | input | 1 | 1 forwards the preamble, 0 strips it; sampled at qualification |
| crs_follow_dv | input | 1 | 1 drops carrier sense together with data-valid; sampled at qualification |
| bit_vld | input | 1 | One-clock strobe marking a decoded bit |
| bit_in | input | 1 | Decoded bit value, used when `bit_vld` is high |
| eof | input | 1 | One-clock end-of-frame pulse, never together with `bit_vld` |
| rxd | output | 4 | Receive nibble |
| rx_dv | output | 1 | Receive data valid |
| crs | output | 1 | Carrier sense |

## Verification
The hardest situation to reach is a frame whose end leaves a specific number of leftover bits in a specific option combination. The padded closing nibble and the split release of `crs` and `rx_dv` only show up when one to three bits trail a full byte and carrier sense is not tied to data-valid. The stimulus drives whole frames bit by bit from tasks. It appends exactly k trailing bits for every k from 1 to 7, and rotates the strip/pass option and the carrier-sense option across those frames, so that each dribble rule is seen under both release choices. The abort path is reached by qualifying a preamble and then sending two zeros before any delimiter.

// File: rtl/rxnib_pkg.sv
package rxnib_pkg;
  localparam int MII_W = 4;
  localparam logic [MII_W-1:0] NIB_PRE = 4'h5;
  localparam logic [MII_W-1:0] NIB_SFD = 4'hD;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_PRE,
    ST_SFD2,
    ST_BODY,
    ST_TAIL
  } fr_state_e;
endpackage

// File: rtl/rxnib_pre_det.sv
module rxnib_pre_det #(
  parameter int PRE_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_vld,
  input  logic bit_in,
  output logic qual_hit,
  output logic rep_one,
  output logic rep_zero
);
  function automatic logic [PRE_BITS-1:0] alt_pattern();
    logic [PRE_BITS-1:0] p;
    for (int i = 0; i < PRE_BITS; i++) p[i] = (i % 2) == 1;
    return p;
  endfunction

  localparam logic [PRE_BITS-1:0] ALT_PAT = alt_pattern();

  logic [PRE_BITS-1:0] hist_q, hist_d;
  logic [PRE_BITS-1:0] window;

  assign window   = {hist_q[PRE_BITS-2:0], bit_in};
  assign qual_hit = bit_vld && (window == ALT_PAT);
  assign rep_one  = bit_vld && bit_in && hist_q[0];
  assign rep_zero = bit_vld && !bit_in && !hist_q[0];

  always_comb begin
    hist_d = hist_q;
    if (clr)          hist_d = '0;
    else if (bit_vld) hist_d = window;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  // R5: after a clear, a fresh alternating run is needed before qualification
  p_fresh_after_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !qual_hit);
endmodule

// File: rtl/rxnib_nib_asm.sv
module rxnib_nib_asm #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bit_vld,
  input  logic             bit_in,
  output logic             done,
  output logic [NIB_W-1:0] full,
  output logic [NIB_W-1:0] pad,
  output logic             partial,
  output logic             hi_half
);
  localparam int CW = (NIB_W > 1) ? $clog2(NIB_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(NIB_W - 1);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic [NIB_W-1:0] nib_q, nib_d;
  logic             half_q, half_d;

  assign done    = bit_vld && (cnt_q == LAST);
  assign partial = (cnt_q != '0);
  assign hi_half = half_q;

  for (genvar i = 0; i < NIB_W; i++) begin : g_lane
    assign full[i] = (CW'(i) == cnt_q) ? bit_in : nib_q[i];
    assign pad[i]  = (CW'(i) < cnt_q) ? nib_q[i] : 1'b1;
  end

  always_comb begin
    cnt_d  = cnt_q;
    nib_d  = nib_q;
    half_d = half_q;
    if (clr) begin
      cnt_d  = '0;
      half_d = 1'b0;
    end else if (bit_vld) begin
      nib_d[cnt_q] = bit_in;
      if (done) begin
        cnt_d  = '0;
        half_d = !half_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      nib_q  <= '0;
      half_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      nib_q  <= nib_d;
      half_q <= half_d;
    end
  end

  // R8: every completed nibble moves the byte position between low and high halves
  p_half_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> (hi_half != $past(hi_half)));
endmodule

// File: rtl/rxnib_mii_framer.sv
module rxnib_mii_framer
  import rxnib_pkg::*;
#(
  parameter int PRE_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_pass,
  input  logic             crs_follow_dv,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             eof,
  output logic [MII_W-1:0] rxd,
  output logic             rx_dv,
  output logic             crs
);
  fr_state_e        state_q, state_d;
  logic             mode_q, mode_d;
  logic             cwd_q, cwd_d;
  logic [MII_W-1:0] rxd_q, rxd_d;
  logic             dv_q, dv_d;
  logic             crs_q, crs_d;
  logic             abort;

  logic             qual_hit, rep_one, rep_zero;
  logic             asm_clr, asm_done, asm_partial, asm_hi, pad_need;
  logic [MII_W-1:0] asm_full, asm_pad;

  rxnib_pre_det #(.PRE_BITS(PRE_BITS)) u_pre_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (eof || abort),
    .bit_vld  (bit_vld),
    .bit_in   (bit_in),
    .qual_hit (qual_hit),
    .rep_one  (rep_one),
    .rep_zero (rep_zero)
  );

  assign asm_clr = (state_q != ST_BODY) && (state_q != ST_SFD2);

  rxnib_nib_asm #(.NIB_W(MII_W)) u_nib_asm (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (asm_clr),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .done    (asm_done),
    .full    (asm_full),
    .pad     (asm_pad),
    .partial (asm_partial),
    .hi_half (asm_hi)
  );

  assign pad_need = asm_partial && !asm_hi;

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    cwd_d   = cwd_q;
    rxd_d   = rxd_q;
    dv_d    = dv_q;
    crs_d   = crs_q;
    abort   = 1'b0;
    unique case (state_q)
      ST_HUNT: begin
        if (qual_hit && !eof) begin
          state_d = ST_PRE;
          mode_d  = pre_pass;
          cwd_d   = crs_follow_dv;
          crs_d   = 1'b1;
          if (pre_pass) begin
            dv_d  = 1'b1;
            rxd_d = NIB_PRE;
          end
        end
      end
      ST_PRE: begin
        if (eof || rep_zero) begin
          abort   = rep_zero;
          state_d = ST_HUNT;
          dv_d    = 1'b0;
          crs_d   = 1'b0;
          rxd_d   = '0;
        end else if (rep_one) begin
          state_d = mode_q ? ST_BODY : ST_SFD2;
          dv_d    = 1'b1;
          rxd_d   = mode_q ? NIB_SFD : NIB_PRE;
        end
      end
      ST_SFD2: begin
        if (eof) begin
          state_d = ST_HUNT;
          dv_d    = 1'b0;
          crs_d   = 1'b0;
          rxd_d   = '0;
        end else begin
          state_d = ST_BODY;
          rxd_d   = NIB_SFD;
        end
      end
      ST_BODY: begin
        if (eof) begin
          if (pad_need) begin
            state_d = ST_TAIL;
            rxd_d   = asm_pad;
            if (!cwd_q) crs_d = 1'b0;
          end else begin
            state_d = ST_HUNT;
            dv_d    = 1'b0;
            crs_d   = 1'b0;
            rxd_d   = '0;
          end
        end else if (asm_done) begin
          rxd_d = asm_full;
        end
      end
      ST_TAIL: begin
        state_d = ST_HUNT;
        dv_d    = 1'b0;
        crs_d   = 1'b0;
        rxd_d   = '0;
      end
      default: begin
        state_d = ST_HUNT;
        dv_d    = 1'b0;
        crs_d   = 1'b0;
        rxd_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      mode_q  <= 1'b0;
      cwd_q   <= 1'b0;
      rxd_q   <= '0;
      dv_q    <= 1'b0;
      crs_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      cwd_q   <= cwd_d;
      rxd_q   <= rxd_d;
      dv_q    <= dv_d;
      crs_q   <= crs_d;
    end
  end

  assign rxd   = rxd_q;
  assign rx_dv = dv_q;
  assign crs   = crs_q;

  // R10: data lines are quiet whenever data-valid is low
  p_rxd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dv |-> (rxd == '0));
  // R2: carrier sense only rises after a qualified preamble
  p_crs_needs_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crs) |-> $past(qual_hit));
  // R4: in pass mode data-valid and carrier sense rise together
  p_pass_joint_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_dv) && mode_q) |-> $rose(crs));
  // R3: strip mode opens with the delimiter nibbles 5 then D
  p_strip_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_dv) && !mode_q) |-> (rxd == NIB_PRE));
  p_strip_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_dv) && !mode_q) |=> (rxd == NIB_SFD));
  // R9: data-valid without carrier only while a closing nibble is shown with early release
  p_dv_without_crs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dv && !crs) |-> (state_q == ST_TAIL && !cwd_q));
  // R6: end of frame with nothing to pad closes the interface next clock
  p_eof_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && state_q == ST_BODY && !pad_need) |=> (!rx_dv && !crs));
endmodule

// File: tb/test_rxnib_mii_framer.sv
module test_rxnib_mii_framer;
  logic       clk;
  logic       rst_n;
  logic       pre_pass;
  logic       crs_follow_dv;
  logic       bit_vld;
  logic       bit_in;
  logic       eof;
  logic [3:0] rxd;
  logic       rx_dv;
  logic       crs;

  int n_chk;
  int n_fail;
  logic [5:0] s1, s2;
  localparam logic [6:0] DRIB = 7'b0100001;

  rxnib_mii_framer i_rxnib_mii_framer (
    .clk           (clk),
    .rst_n         (rst_n),
    .pre_pass      (pre_pass),
    .crs_follow_dv (crs_follow_dv),
    .bit_vld       (bit_vld),
    .bit_in        (bit_in),
    .eof           (eof),
    .rxd           (rxd),
    .rx_dv         (rx_dv),
    .crs           (crs)
  );

  initial clk = 1'b0;
  always #5 clk = !clk;

  function automatic logic [5:0] obs();
    return {rx_dv, crs, rxd};
  endfunction

  function automatic logic [5:0] mk(logic dv, logic cs, logic [3:0] d);
    return {dv, cs, d};
  endfunction

  task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got dv=%b crs=%b rxd=%h, expected dv=%b crs=%b rxd=%h",
               tag, act[5], act[4], act[3:0], exp[5], exp[4], exp[3:0]);
    end
  endtask

  task automatic send_bit(logic b);
    @(negedge clk);
    bit_vld = 1'b1;
    bit_in  = b;
    @(negedge clk);
    bit_vld = 1'b0;
    s1 = obs();
    @(negedge clk);
    s2 = obs();
  endtask

  task automatic send_eof();
    @(negedge clk);
    eof = 1'b1;
    @(negedge clk);
    eof = 1'b0;
    s1 = obs();
    @(negedge clk);
    s2 = obs();
  endtask

  function automatic logic [7:0] body_byte(int i);
    return 8'hA7 + 8'(i) * 8'h3B;
  endfunction

  task automatic run_frame(logic pass, logic cwd, int npre, int nbytes, int k);
    int len;
    logic [3:0] pad;
    logic [7:0] b;
    pre_pass      = pass;
    crs_follow_dv = cwd;
    len = npre + 8;
    for (int i = 0; i < len; i++) begin
      send_bit((i == len - 1) ? 1'b1 : ((i % 2) == 0));
      if (i == 6) chk("R2 no carrier before qualification", s1, mk(0, 0, 0));
      else if (i == 7) begin
        if (pass) chk("R4 joint rise at qualification", s1, mk(1, 1, 4'h5));
        else      chk("R2 carrier at qualification, strip", s1, mk(0, 1, 0));
      end else if (i > 7 && i < len - 1) begin
        if (pass) chk("R4 preamble forwarded", s1, mk(1, 1, 4'h5));
        else      chk("R3 preamble withheld", s1, mk(0, 1, 0));
      end else if (i == len - 1) begin
        if (pass) chk("R4 delimiter nibble D", s1, mk(1, 1, 4'hD));
        else begin
          chk("R3 delimiter first nibble 5", s1, mk(1, 1, 4'h5));
          chk("R3 delimiter second nibble D", s2, mk(1, 1, 4'hD));
        end
      end
    end
    for (int j = 0; j < nbytes; j++) begin
      b = body_byte(j);
      for (int t = 0; t < 8; t++) begin
        send_bit(b[t]);
        if (t == 3) chk("R1 low nibble", s1, mk(1, 1, b[3:0]));
        if (t == 7) chk("R1 high nibble", s1, mk(1, 1, b[7:4]));
      end
    end
    for (int t = 0; t < k; t++) begin
      send_bit(DRIB[t]);
      if (t == 3) chk("R8 dribble low nibble delivered", s1, mk(1, 1, DRIB[3:0]));
    end
    send_eof();
    if (k >= 1 && k <= 3) begin
      pad = 4'hF;
      for (int t = 0; t < k; t++) pad[t] = DRIB[t];
      chk("R7 padded closing nibble", s1, mk(1, cwd, pad));
      chk("R9 release after closing nibble", s2, mk(0, 0, 0));
    end else if (k == 0) begin
      chk("R6 clean close after eof", s1, mk(0, 0, 0));
    end else begin
      chk("R8 partial upper nibble discarded", s1, mk(0, 0, 0));
      chk("R8 stays closed", s2, mk(0, 0, 0));
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic run_abort();
    pre_pass      = 1'b0;
    crs_follow_dv = 1'b0;
    for (int i = 0; i < 8; i++) send_bit((i % 2) == 0);
    chk("R5 qualified before abort", s1, mk(0, 1, 0));
    send_bit(1'b0);
    chk("R5 carrier drops on repeated zero", s1, mk(0, 0, 0));
    send_bit(1'b1);
    send_bit(1'b1);
    chk("R5 no data-valid after abort", s1, mk(0, 0, 0));
    send_eof();
    chk("R5 idle after abort", s1, mk(0, 0, 0));
    repeat (4) @(negedge clk);
  endtask

  task automatic run_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset state", obs(), mk(0, 0, 0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 idle after reset", obs(), mk(0, 0, 0));
  endtask

  logic finished;

  initial begin
    finished      = 1'b0;
    n_chk         = 0;
    n_fail        = 0;
    pre_pass      = 1'b0;
    crs_follow_dv = 1'b0;
    bit_vld       = 1'b0;
    bit_in        = 1'b0;
    eof           = 1'b0;
    run_reset();
    run_frame(1'b0, 1'b0, 56, 3, 0);
    run_frame(1'b1, 1'b0, 56, 3, 0);
    run_frame(1'b0, 1'b1, 2, 1, 0);
    for (int k = 1; k <= 7; k++)
      run_frame(k[0], k[1], 6, 2, k);
    run_frame(1'b0, 1'b0, 10, 1, 1);
    run_frame(1'b0, 1'b1, 10, 1, 3);
    run_abort();
    run_frame(1'b1, 1'b1, 8, 2, 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule